// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits in front of a page write engine and watches every qualified byte write (address, data, one-cycle strobe). It recognises a three-write enable sequence and a six-write disable sequence, keeps a single protection flag, and decides whether the page load in progress may reach the array. Command bytes that match a sequence step are swallowed. Every other byte is passed on to the page buffer one cycle later.

When the page load closes, the block reports whether the load may be committed. A load may be committed when protection is off, or when the enable sequence was written during that load. A protected load without that prefix is reported as not committable. The write engine still runs its busy period for such a load, but the array is left unchanged. The reset value of the protection flag comes from an input. This input models the flag being kept across power cycles.

The matcher states are `SQ_IDLE`, `SQ_K1` (first key seen), `SQ_K2` (second key seen), `SQ_DARM` (disable armed), `SQ_DK1` and `SQ_DK2` (first and second key repeated after arming). The transitions are:

- key-1 write `IDLE→K1`
- key-2 write `K1→K2`
- enable byte `K2→IDLE`, which sets protection and unlocks the load
- arm byte `K2→DARM`
- key-1 write `DARM→DK1`
- key-2 write `DK1→DK2`
- disable byte `DK2→IDLE`, which clears protection
- any mismatching write, an expired gap window, or a load close returns the matcher to `IDLE`

Top module: `wp_cmd_guard`

## Requirements
- R1: During and after reset the protection flag holds the value of `i_prot_init`, the matcher is idle, and neither `o_fwd_valid` nor `o_close_valid` is asserted.
- R2: The writes (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), in that order, set protection. The load that contains them reports `o_commit_ok`=1 and `o_protected`=1.
- R3: A write that completes a sequence step is never forwarded. A later ordinary write to 0x5555 or 0x2AAA is forwarded like any other byte.
- R4: While protection is set, a load without the enable prefix still forwards its bytes, but its close reports `o_commit_ok`=0 and `o_protected`=1.
- R5: While protection is set, a load that contains the full enable sequence reports `o_commit_ok`=1 and protection stays set.
- R6: The six writes (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x20) clear protection. That load and later plain loads report `o_commit_ok`=1 and `o_protected`=0.
- R7: A write that does not match the next expected step returns the matcher to idle and is forwarded as ordinary data. Key bytes already swallowed stay dropped, and a partial disable sequence leaves protection set.
- R8: A sequence step is accepted only if it arrives at most `WIN_CYCLES` clock cycles after the previous one. At a gap of `WIN_CYCLES`+1 the matcher has already returned to idle, and the late write is decoded from idle.
- R9: One cycle after `i_load_close`, `o_close_valid` pulses once. At that pulse, `o_commit_ok` = (not protected) or (unlocked in this load), and `o_protected` gives the flag. The close clears the unlock and idles the matcher.
- R10: Each forwarded byte appears on `o_fwd_valid`/`o_fwd_addr`/`o_fwd_data` exactly one cycle after its strobe, with the same address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_prot_init | input | 1 | Value the protection flag takes in reset |
| i_wr_valid | input | 1 | Qualified byte write strobe, one cycle per byte |
| i_wr_addr | input | ADDR_W | Byte write address |
| i_wr_data | input | DATA_W | Byte write data |
| i_load_close | input | 1 | Page load closes; a write in the same cycle belongs to the next load |
| o_fwd_valid | output | 1 | Byte forwarded to the page buffer |
| o_fwd_addr | output | ADDR_W | Forwarded address |
| o_fwd_data | output | DATA_W | Forwarded data |
| o_close_valid | output | 1 | Close verdict valid |
| o_commit_ok | output | 1 | Load may be committed to the array |
| o_protected | output | 1 | Protection flag at the close |

## Verification
The hardest case to reach is the gap-window boundary. A sequence step that arrives after exactly `WIN_CYCLES` idle-gap cycles must still count. One cycle later, the matcher must already have dropped back to idle, so the late enable byte is forwarded as data. The stimulus places idle cycles so that the spacing between sampled strobes is exactly `WIN_CYCLES` and then `WIN_CYCLES`+1. The close verdict of each load then shows whether the unlock was granted.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_K1   = 3'd1,
        SQ_K2   = 3'd2,
        SQ_DARM = 3'd3,
        SQ_DK1  = 3'd4,
        SQ_DK2  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/wp_gap_timer.sv
module wp_gap_timer #(
    parameter int WIN_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic wr_valid,
    input  logic flush,
    output logic expire
);
    localparam int CW = $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] gap_q;

    // gap counter restarts on every write; saturates at the last allowed cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (wr_valid || flush || !armed) begin
            gap_q <= '0;
        end else if (gap_q != LAST) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign expire = armed && !wr_valid && !flush && (gap_q == LAST);

endmodule

// File: rtl/wp_seq_matcher.sv
module wp_seq_matcher
    import wp_guard_pkg::*;
#(
    parameter int                ADDR_W = 15,
    parameter int                DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_P = 15'h5555,
    parameter logic [ADDR_W-1:0] ADDR_Q = 15'h2AAA,
    parameter logic [DATA_W-1:0] D_KEY1 = 8'hAA,
    parameter logic [DATA_W-1:0] D_KEY2 = 8'h55,
    parameter logic [DATA_W-1:0] D_EN   = 8'hA0,
    parameter logic [DATA_W-1:0] D_ARM  = 8'h80,
    parameter logic [DATA_W-1:0] D_DIS  = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flush,
    input  logic              expire,
    output logic              consume,
    output logic              en_hit,
    output logic              dis_hit,
    output seq_state_e        state_o
);
    seq_state_e st_q, st_nxt, base, adv;
    logic       step_ok;

    logic at_p, at_q;
    logic hit_key1, hit_key2, hit_en, hit_arm, hit_dis;

    assign at_p     = (wr_addr == ADDR_P);
    assign at_q     = (wr_addr == ADDR_Q);
    assign hit_key1 = at_p && (wr_data == D_KEY1);
    assign hit_key2 = at_q && (wr_data == D_KEY2);
    assign hit_en   = at_p && (wr_data == D_EN);
    assign hit_arm  = at_p && (wr_data == D_ARM);
    assign hit_dis  = at_p && (wr_data == D_DIS);

    // a close or an expired window drops progress before this cycle's write
    assign base = (flush || expire) ? SQ_IDLE : st_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SQ_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // step decode and outputs
    always_comb begin
        step_ok = 1'b0;
        adv     = SQ_IDLE;
        en_hit  = 1'b0;
        dis_hit = 1'b0;
        unique case (base)
            SQ_IDLE: begin
                step_ok = hit_key1;
                adv     = SQ_K1;
            end
            SQ_K1: begin
                step_ok = hit_key2;
                adv     = SQ_K2;
            end
            SQ_K2: begin
                step_ok = hit_en || hit_arm;
                adv     = hit_arm ? SQ_DARM : SQ_IDLE;
                en_hit  = wr_valid && hit_en;
            end
            SQ_DARM: begin
                step_ok = hit_key1;
                adv     = SQ_DK1;
            end
            SQ_DK1: begin
                step_ok = hit_key2;
                adv     = SQ_DK2;
            end
            SQ_DK2: begin
                step_ok = hit_dis;
                adv     = SQ_IDLE;
                dis_hit = wr_valid && hit_dis;
            end
            default: begin
                step_ok = 1'b0;
                adv     = SQ_IDLE;
            end
        endcase
        consume = wr_valid && step_ok;
    end

    // next state
    always_comb begin
        if (wr_valid) begin
            st_nxt = step_ok ? adv : SQ_IDLE;
        end else begin
            st_nxt = base;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/wp_commit_gate.sv
module wp_commit_gate #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_init,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              consume,
    input  logic              en_hit,
    input  logic              dis_hit,
    input  logic              load_close,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_data,
    output logic              close_valid,
    output logic              commit_ok,
    output logic              prot_snap,
    output logic              prot_live
);
    logic prot_q;
    logic unlock_q;

    // protection flag: reset value supplied from outside
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= prot_init;
        end else if (en_hit) begin
            prot_q <= 1'b1;
        end else if (dis_hit) begin
            prot_q <= 1'b0;
        end
    end

    // unlock for the load in progress; an enable in the close cycle opens the next load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlock_q <= 1'b0;
        end else if (en_hit) begin
            unlock_q <= 1'b1;
        end else if (load_close) begin
            unlock_q <= 1'b0;
        end
    end

    // byte forwarding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_addr  <= '0;
            fwd_data  <= '0;
        end else begin
            fwd_valid <= wr_valid && !consume;
            if (wr_valid && !consume) begin
                fwd_addr <= wr_addr;
                fwd_data <= wr_data;
            end
        end
    end

    // close verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            close_valid <= 1'b0;
            commit_ok   <= 1'b0;
            prot_snap   <= 1'b0;
        end else begin
            close_valid <= load_close;
            if (load_close) begin
                commit_ok <= !prot_q || unlock_q;
                prot_snap <= prot_q;
            end
        end
    end

    assign prot_live = prot_q;

endmodule

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard
    import wp_guard_pkg::*;
#(
    parameter int                ADDR_W     = 15,
    parameter int                DATA_W     = 8,
    parameter int                WIN_CYCLES = 16,
    parameter logic [ADDR_W-1:0] ADDR_P     = 15'h5555,
    parameter logic [ADDR_W-1:0] ADDR_Q     = 15'h2AAA,
    parameter logic [DATA_W-1:0] D_KEY1     = 8'hAA,
    parameter logic [DATA_W-1:0] D_KEY2     = 8'h55,
    parameter logic [DATA_W-1:0] D_EN       = 8'hA0,
    parameter logic [DATA_W-1:0] D_ARM      = 8'h80,
    parameter logic [DATA_W-1:0] D_DIS      = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_prot_init,
    input  logic              i_wr_valid,
    input  logic [ADDR_W-1:0] i_wr_addr,
    input  logic [DATA_W-1:0] i_wr_data,
    input  logic              i_load_close,
    output logic              o_fwd_valid,
    output logic [ADDR_W-1:0] o_fwd_addr,
    output logic [DATA_W-1:0] o_fwd_data,
    output logic              o_close_valid,
    output logic              o_commit_ok,
    output logic              o_protected
);
    seq_state_e st;
    logic       consume, en_hit, dis_hit, expire, prot_live, armed;

    assign armed = (st != SQ_IDLE);

    wp_gap_timer #(
        .WIN_CYCLES (WIN_CYCLES)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed),
        .wr_valid (i_wr_valid),
        .flush    (i_load_close),
        .expire   (expire)
    );

    wp_seq_matcher #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W),
        .ADDR_P (ADDR_P), .ADDR_Q (ADDR_Q),
        .D_KEY1 (D_KEY1), .D_KEY2 (D_KEY2),
        .D_EN   (D_EN),   .D_ARM  (D_ARM), .D_DIS (D_DIS)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (i_wr_valid),
        .wr_addr  (i_wr_addr),
        .wr_data  (i_wr_data),
        .flush    (i_load_close),
        .expire   (expire),
        .consume  (consume),
        .en_hit   (en_hit),
        .dis_hit  (dis_hit),
        .state_o  (st)
    );

    wp_commit_gate #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .prot_init   (i_prot_init),
        .wr_valid    (i_wr_valid),
        .wr_addr     (i_wr_addr),
        .wr_data     (i_wr_data),
        .consume     (consume),
        .en_hit      (en_hit),
        .dis_hit     (dis_hit),
        .load_close  (i_load_close),
        .fwd_valid   (o_fwd_valid),
        .fwd_addr    (o_fwd_addr),
        .fwd_data    (o_fwd_data),
        .close_valid (o_close_valid),
        .commit_ok   (o_commit_ok),
        .prot_snap   (o_protected),
        .prot_live   (prot_live)
    );

endmodule

// File: rtl/wp_cmd_guard_chk.sv
module wp_cmd_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic       load_close,
    input logic       consume,
    input logic       en_hit,
    input logic       dis_hit,
    input logic       expire,
    input logic       prot_live,
    input logic [2:0] state,
    input logic       fwd_valid,
    input logic       close_valid,
    input logic       commit_ok,
    input logic       prot_snap
);
    AST_EN_SETS_PROT:   assert property (@(posedge clk) disable iff (!rst_n) en_hit |=> prot_live); // R2
    AST_PROT_RISE_SRC:  assert property (@(posedge clk) disable iff (!rst_n) $rose(prot_live) |-> $past(en_hit)); // R2
    AST_CMD_NOT_FWD:    assert property (@(posedge clk) disable iff (!rst_n) consume |=> !fwd_valid); // R3
    AST_LOCKED_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) (close_valid && !commit_ok) |-> prot_snap); // R4
    AST_DIS_CLEARS:     assert property (@(posedge clk) disable iff (!rst_n) dis_hit |=> !prot_live); // R6
    AST_MISS_TO_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) (wr_valid && !consume) |=> (state == 3'd0)); // R7
    AST_EXPIRE_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) expire |=> (state == 3'd0)); // R8
    AST_CLOSE_SRC:      assert property (@(posedge clk) disable iff (!rst_n) close_valid |-> $past(load_close)); // R9
    AST_FWD_SRC:        assert property (@(posedge clk) disable iff (!rst_n) fwd_valid |-> $past(wr_valid)); // R10
endmodule

bind wp_cmd_guard wp_cmd_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (i_wr_valid),
    .load_close  (i_load_close),
    .consume     (consume),
    .en_hit      (en_hit),
    .dis_hit     (dis_hit),
    .expire      (expire),
    .prot_live   (prot_live),
    .state       (st),
    .fwd_valid   (o_fwd_valid),
    .close_valid (o_close_valid),
    .commit_ok   (o_commit_ok),
    .prot_snap   (o_protected)
);

// File: tb/sim_wp_cmd_guard.sv
module sim_wp_cmd_guard;
    localparam int WIN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_prot_init = 1'b0;
    logic        i_wr_valid = 1'b0;
    logic [14:0] i_wr_addr = '0;
    logic [7:0]  i_wr_data = '0;
    logic        i_load_close = 1'b0;
    logic        o_fwd_valid, o_close_valid, o_commit_ok, o_protected;
    logic [14:0] o_fwd_addr;
    logic [7:0]  o_fwd_data;

    always #5 clk = ~clk;

    wp_cmd_guard #(.WIN_CYCLES(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .i_prot_init(i_prot_init),
        .i_wr_valid(i_wr_valid), .i_wr_addr(i_wr_addr), .i_wr_data(i_wr_data),
        .i_load_close(i_load_close),
        .o_fwd_valid(o_fwd_valid), .o_fwd_addr(o_fwd_addr), .o_fwd_data(o_fwd_data),
        .o_close_valid(o_close_valid), .o_commit_ok(o_commit_ok), .o_protected(o_protected)
    );

    typedef struct { logic [14:0] a; logic [7:0] d; string tag; } fwd_t;
    typedef struct { logic ok; logic pr; string tag; } cls_t;

    fwd_t fq[$];
    cls_t cq[$];
    int   vec = 0;
    int   bad = 0;
    bit   done = 1'b0;

    task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit fwd, input string tag);
        fwd_t it;
        @(posedge clk); #1;
        i_wr_valid = 1'b1; i_wr_addr = a; i_wr_data = d;
        if (fwd) begin
            it.a = a; it.d = d; it.tag = tag;
            fq.push_back(it);
        end
        @(posedge clk); #1;
        i_wr_valid = 1'b0;
    endtask

    task automatic close_load(input logic ok, input logic pr, input string tag);
        cls_t it;
        @(posedge clk); #1;
        i_load_close = 1'b1;
        it.ok = ok; it.pr = pr; it.tag = tag;
        cq.push_back(it);
        @(posedge clk); #1;
        i_load_close = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic seq_enable(input string tag);
        wr(15'h5555, 8'hAA, 1'b0, tag);
        wr(15'h2AAA, 8'h55, 1'b0, tag);
        wr(15'h5555, 8'hA0, 1'b0, tag);
    endtask

    task automatic do_reset(input logic init);
        @(negedge clk);
        rst_n = 1'b0; i_prot_init = init;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // monitor: compares design results against the scoreboard queues
    always @(negedge clk) begin
        fwd_t f;
        cls_t c;
        if (rst_n && !done) begin
            if (o_fwd_valid) begin
                vec++;
                if (fq.size() == 0) begin
                    bad++;
                    $display("FAIL R10 unexpected forward: actual %h/%h expected none", o_fwd_addr, o_fwd_data);
                end else begin
                    f = fq.pop_front();
                    if (o_fwd_addr !== f.a || o_fwd_data !== f.d) begin
                        bad++;
                        $display("FAIL %s forward: actual %h/%h expected %h/%h", f.tag, o_fwd_addr, o_fwd_data, f.a, f.d);
                    end
                end
            end
            if (o_close_valid) begin
                vec++;
                if (cq.size() == 0) begin
                    bad++;
                    $display("FAIL R9 unexpected close verdict: actual ok=%b prot=%b expected none", o_commit_ok, o_protected);
                end else begin
                    c = cq.pop_front();
                    if (o_commit_ok !== c.ok || o_protected !== c.pr) begin
                        bad++;
                        $display("FAIL %s close: actual ok=%b prot=%b expected ok=%b prot=%b", c.tag, o_commit_ok, o_protected, c.ok, c.pr);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            $display("FAIL watchdog expired: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        @(negedge clk);
        vec++;
        if (o_fwd_valid !== 1'b0 || o_close_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 outputs after reset: actual fwd=%b close=%b expected 0/0", o_fwd_valid, o_close_valid);
        end

        // R1 R10: plain load with protection off
        wr(15'h0100, 8'h11, 1'b1, "R10");
        wr(15'h0101, 8'h22, 1'b1, "R10");
        close_load(1'b1, 1'b0, "R1");

        // R2 R3: enable sequence swallowed, protection set, load committed
        seq_enable("R3");
        wr(15'h0200, 8'h33, 1'b1, "R2");
        close_load(1'b1, 1'b1, "R2");

        // R4: protected load without prefix
        wr(15'h0300, 8'h44, 1'b1, "R4");
        close_load(1'b0, 1'b1, "R4");

        // R5: protected load with prefix
        seq_enable("R5");
        wr(15'h0400, 8'h55, 1'b1, "R5");
        close_load(1'b1, 1'b1, "R5");

        // R7: mismatch after first key
        wr(15'h5555, 8'hAA, 1'b0, "R7");
        wr(15'h2AAA, 8'h56, 1'b1, "R7");
        wr(15'h0500, 8'h66, 1'b1, "R7");
        close_load(1'b0, 1'b1, "R7");

        // R7: partial disable leaves protection set
        wr(15'h5555, 8'hAA, 1'b0, "R7");
        wr(15'h2AAA, 8'h55, 1'b0, "R7");
        wr(15'h5555, 8'h80, 1'b0, "R7");
        wr(15'h5555, 8'h11, 1'b1, "R7");
        close_load(1'b0, 1'b1, "R7");

        // R8: gap of WIN+1 cycles expires the matcher; late enable byte is data
        wr(15'h5555, 8'hAA, 1'b0, "R8");
        wr(15'h2AAA, 8'h55, 1'b0, "R8");
        idle(WIN - 1);
        wr(15'h5555, 8'hA0, 1'b1, "R8");
        close_load(1'b0, 1'b1, "R8");

        // R8: gaps of exactly WIN cycles are still accepted
        wr(15'h5555, 8'hAA, 1'b0, "R8");
        idle(WIN - 2);
        wr(15'h2AAA, 8'h55, 1'b0, "R8");
        idle(WIN - 2);
        wr(15'h5555, 8'hA0, 1'b0, "R8");
        wr(15'h0600, 8'h77, 1'b1, "R8");
        close_load(1'b1, 1'b1, "R8");

        // R6 R3: disable sequence, then reuse of a command address as data
        wr(15'h5555, 8'hAA, 1'b0, "R6");
        wr(15'h2AAA, 8'h55, 1'b0, "R6");
        wr(15'h5555, 8'h80, 1'b0, "R6");
        wr(15'h5555, 8'hAA, 1'b0, "R6");
        wr(15'h2AAA, 8'h55, 1'b0, "R6");
        wr(15'h5555, 8'h20, 1'b0, "R6");
        wr(15'h5555, 8'h99, 1'b1, "R3");
        close_load(1'b1, 1'b0, "R6");
        wr(15'h2AAA, 8'h12, 1'b1, "R3");
        close_load(1'b1, 1'b0, "R6");

        // R9: close without data bytes, protection off
        close_load(1'b1, 1'b0, "R9");

        // R1: reset with the flag preset
        idle(3);
        do_reset(1'b1);
        @(negedge clk);
        vec++;
        if (o_close_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 close after reset: actual %b expected 0", o_close_valid);
        end
        wr(15'h0700, 8'h88, 1'b1, "R1");
        close_load(1'b0, 1'b1, "R1");

        idle(4);
        if (fq.size() != 0 || cq.size() != 0) begin
            vec++;
            bad++;
            $display("FAIL R9 missing results: actual %0d/%0d pending expected 0/0", fq.size(), cq.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule